// File: doc/BRIEF.md
# Fail-Equal Boom Pair Deployment Controller

This block runs the two deployment motors of a pair of opposing wire booms. Each boom has a sensor that gives one pulse per turn click, and one click is 10 cm of wire. The block counts these pulses. A deployment starts with a command that gives an absolute target click count and a selection. The selection names the boom pair together or one boom alone. A motor runs until its counter reaches the target.

When both booms run together, the block keeps them balanced. If one boom gets ahead of its partner by the allowed margin, its motor pauses and waits for the slower boom to catch up. The default margin is two clicks. A separate deployment enable gates every motor drive. If a driven motor gives no click within a timeout, the block flags a stall and halts the session.

Top module: `boom_pair_deploy`

## Requirements
- R1: While `arm_en` is low, both `drive` bits are 0 in the same cycle. Dropping `arm_en` ends a running session: `busy` is 0 after the next clock edge, and the session does not resume when `arm_en` returns.
- R2: A `start` pulse is accepted only while `arm_en` is high and `busy` is 0. A `start` given while disabled or during a session changes nothing.
- R3: The `mode` value is latched at an accepted start, and bit 0 is boom A and bit 1 is boom B. 2'b11 selects both booms together. 2'b01 selects boom A alone. 2'b10 selects boom B alone. 2'b00 selects no boom and finishes at once with `done`. A boom that is not selected is never driven.
- R4: A click on `click[i]` increments that boom's counter only in a cycle when its motor drive is active. Otherwise the click is ignored. Counters are cumulative and return to 0 only on `rst`.
- R5: When both booms are selected, a boom whose count is at least MARGIN (default 2) above its partner is not driven. It resumes once the partner closes the gap, so the two counts never differ by more than MARGIN.
- R6: Each selected motor stops when its count reaches the latched target. When no selected boom still needs clicks, `busy` falls and `done` rises. `done` stays high until the next accepted start. A target already reached gives `done` with no drive.
- R7: If a motor is driven for STALL_CYC consecutive cycles with no click, both drives stop at the end of that cycle. That boom's `stall` bit (bit 0 for A, bit 1 for B) is set, `busy` falls and `done` stays 0. `stall` is cleared by the next accepted start.
- R8: After reset, `drive`, `count_a`, `count_b`, `busy`, `done` and `stall` are all 0. The drives rise one clock edge after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_en | input | 1 | Deployment enable; gates all drives |
| start | input | 1 | Start pulse for a deployment session |
| mode | input | 2 | Boom selection (R3 encoding) |
| target | input | CNT_W | Absolute click count to deploy to |
| click | input | 2 | One-cycle click pulses, bit 0 boom A, bit 1 boom B |
| drive | output | 2 | Motor drive, bit 0 boom A, bit 1 boom B |
| count_a | output | CNT_W | Boom A click count |
| count_b | output | CNT_W | Boom B click count |
| busy | output | 1 | Session in progress |
| done | output | 1 | Last session reached its target |
| stall | output | 2 | Per-boom stall flags of the last session |

## Verification
The bench runs pair deployments where one boom clicks much faster than the other, in both directions. A controller with a wrong pause compare would let the counts drift more than two clicks apart, or would drive the leading motor. It would also stall a session by pausing the slow boom.

Single-boom modes, an empty selection and a target that is already reached are all tested. A wrong mode decode would move the idle boom, or would hang without raising `done`.

A silent motor must cause a stall after exactly the timeout length. A start pulse given during that stall must be ignored. An off-by-one timer would change the measured drive length. A design that accepts the stray start would report the wrong boom.

The enable is dropped in the middle of a deployment. The drives must fall in the same cycle. Clicks that arrive with no drive must not be counted, and the session must not restart when the enable returns.

// File: rtl/boom_pkg.sv
package boom_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_A    = 2'b01,
    SEL_B    = 2'b10,
    SEL_PAIR = 2'b11
  } sel_e;
endpackage

// File: rtl/boom_channel.sv
module boom_channel #(
  parameter int CNT_W     = 12,
  parameter int STALL_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drive,
  input  logic             click,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt,
  output logic             stall_hit
);
  localparam int TMR_W = $clog2(STALL_CYC + 1);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(STALL_CYC - 1);

  logic [TMR_W-1:0] idle_tmr;
  logic             take;

  assign take      = click && drive;
  assign count_nxt = count + CNT_W'(take);
  assign stall_hit = drive && !click && (idle_tmr == TMR_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      idle_tmr <= '0;
    end else begin
      count <= count_nxt;
      if (!drive || click)
        idle_tmr <= '0;
      else if (idle_tmr != TMR_LAST)
        idle_tmr <= idle_tmr + 1'b1;
    end
  end

  p_count_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    !drive |=> count == $past(count));
endmodule

// File: rtl/deploy_fsm.sv
module deploy_fsm
  import boom_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int MARGIN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_en,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] target,
  input  logic [CNT_W-1:0] cnt     [2],
  input  logic [CNT_W-1:0] cnt_nxt [2],
  input  logic [1:0]       stall_hit,
  output logic [1:0]       drive_q,
  output logic             busy_q,
  output logic             done_q,
  output logic [1:0]       stall_q
);
  localparam int XW = CNT_W + 1;
  localparam logic [XW-1:0] MARGIN_X = XW'(MARGIN);

  sel_e             sel_q;
  logic [CNT_W-1:0] tgt_q;
  logic [1:0]       need, pause;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      need[i]  = sel_q[i] && (cnt_nxt[i] < tgt_q);
      pause[i] = (sel_q == SEL_PAIR) &&
                 ({1'b0, cnt_nxt[i]} >= {1'b0, cnt_nxt[1-i]} + MARGIN_X);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      sel_q   <= SEL_NONE;
      tgt_q   <= '0;
      drive_q <= '0;
      done_q  <= 1'b0;
      stall_q <= '0;
    end else if (!arm_en) begin
      busy_q  <= 1'b0;
      drive_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        sel_q   <= sel_e'(mode);
        tgt_q   <= target;
        done_q  <= 1'b0;
        stall_q <= '0;
      end
    end else if (|stall_hit) begin
      stall_q <= stall_hit;
      busy_q  <= 1'b0;
      drive_q <= '0;
    end else if (need == 2'b00) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
      drive_q <= '0;
    end else begin
      drive_q <= need & ~pause;
    end
  end

  p_arm_off_r1: assert property (@(posedge clk) disable iff (rst)
    !arm_en |=> (drive_q == 2'b00) && !busy_q);
  p_lead_pause_a_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_PAIR && drive_q[0]) |-> ({1'b0, cnt[0]} < {1'b0, cnt[1]} + MARGIN_X));
  p_lead_pause_b_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_PAIR && drive_q[1]) |-> ({1'b0, cnt[1]} < {1'b0, cnt[0]} + MARGIN_X));
  p_target_stop_r6: assert property (@(posedge clk) disable iff (rst)
    drive_q[0] |-> cnt[0] < tgt_q);
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_q |-> drive_q == 2'b00);
  p_unselected_r3: assert property (@(posedge clk) disable iff (rst)
    (drive_q & ~sel_q) == 2'b00);
  p_stall_halt_r7: assert property (@(posedge clk) disable iff (rst)
    (|stall_hit && arm_en) |=> drive_q == 2'b00 && stall_q != 2'b00 && !done_q);
endmodule

// File: rtl/boom_pair_deploy.sv
module boom_pair_deploy #(
  parameter int CNT_W     = 12,
  parameter int MARGIN    = 2,
  parameter int STALL_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm_en,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] target,
  input  logic [1:0]       click,
  output logic [1:0]       drive,
  output logic [CNT_W-1:0] count_a,
  output logic [CNT_W-1:0] count_b,
  output logic             busy,
  output logic             done,
  output logic [1:0]       stall
);
  logic [CNT_W-1:0] cnt     [2];
  logic [CNT_W-1:0] cnt_nxt [2];
  logic [1:0]       stall_hit;
  logic [1:0]       drive_q;

  for (genvar g = 0; g < 2; g++) begin : g_boom
    boom_channel #(.CNT_W(CNT_W), .STALL_CYC(STALL_CYC)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .drive     (drive_q[g]),
      .click     (click[g]),
      .count     (cnt[g]),
      .count_nxt (cnt_nxt[g]),
      .stall_hit (stall_hit[g])
    );
  end

  deploy_fsm #(.CNT_W(CNT_W), .MARGIN(MARGIN)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .arm_en    (arm_en),
    .start     (start),
    .mode      (mode),
    .target    (target),
    .cnt       (cnt),
    .cnt_nxt   (cnt_nxt),
    .stall_hit (stall_hit),
    .drive_q   (drive_q),
    .busy_q    (busy),
    .done_q    (done),
    .stall_q   (stall)
  );

  assign drive   = drive_q & {2{arm_en}};
  assign count_a = cnt[0];
  assign count_b = cnt[1];

  p_gate_r1: assert property (@(posedge clk) disable iff (rst)
    !arm_en |-> drive == 2'b00);
endmodule

// File: tb/boom_pair_deploy_tb.sv
module boom_pair_deploy_tb;
  localparam int CNT_W = 8;
  localparam int STALL = 40;
  localparam int NV = 6;
  // mode, target, click period A, click period B, expected count A, expected count B
  localparam int VEC [NV][6] = '{
    '{3, 10, 3, 7, 10, 10},
    '{3,  6, 9, 2,  6,  6},
    '{1,  5, 4, 3,  5,  0},
    '{2,  7, 4, 3,  0,  7},
    '{0,  5, 3, 3,  0,  0},
    '{3,  0, 3, 3,  0,  0}
  };

  logic clk = 0, rst = 1, arm_en = 0, start = 0;
  logic [1:0] mode = 0, model_click = 0, man_click = 0, click, drive, stall;
  logic [CNT_W-1:0] target = 0, count_a, count_b;
  logic busy, done;
  int checks = 0, fails = 0, cyc = 0;
  int per_a = 0, per_b = 0, ph_a = 0, ph_b = 0;
  bit model_on = 0, pair_mon = 0, viol = 0;

  always #5 clk = ~clk;
  assign click = model_click | man_click;

  boom_pair_deploy #(.CNT_W(CNT_W), .MARGIN(2), .STALL_CYC(STALL)) u_dut (
    .clk(clk), .rst(rst), .arm_en(arm_en), .start(start), .mode(mode),
    .target(target), .click(click), .drive(drive), .count_a(count_a),
    .count_b(count_b), .busy(busy), .done(done), .stall(stall));

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      finish_run();
    end
  end

  // boom model: clicks every per_x driven cycles; period 0 never clicks
  always @(negedge clk) begin
    model_click = 2'b00;
    if (model_on && drive[0] && per_a != 0) begin
      ph_a++;
      if (ph_a == per_a) begin model_click[0] = 1'b1; ph_a = 0; end
    end
    if (model_on && drive[1] && per_b != 0) begin
      ph_b++;
      if (ph_b == per_b) begin model_click[1] = 1'b1; ph_b = 0; end
    end
    if (pair_mon) begin
      if (int'(count_a) > int'(count_b) + 2 || int'(count_b) > int'(count_a) + 2) viol = 1;
      if (drive[0] && int'(count_a) >= int'(count_b) + 2) viol = 1;
      if (drive[1] && int'(count_b) >= int'(count_a) + 2) viol = 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; model_on = 0; ph_a = 0; ph_b = 0;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  task automatic pulse_start(input int m, input int t);
    mode = 2'(m); target = CNT_W'(t); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy; k++) @(negedge clk);
  endtask

  initial begin
    int hi;
    logic [CNT_W-1:0] sa, sb;
    do_reset();
    // R8 reset state
    check(drive == 0 && count_a == 0 && count_b == 0 && !busy && !done && stall == 0,
          "R8 reset", {drive, stall, busy, done}, 0);

    // R2: start while disabled ignored
    pulse_start(3, 5);
    check(!busy && drive == 0, "R2 start disabled", busy, 0);

    // R4: click with no drive ignored
    arm_en = 1; man_click = 2'b11; @(negedge clk); man_click = 0;
    check(count_a == 0 && count_b == 0, "R4 undriven click", count_a + count_b, 0);

    // table of vectors (R3 R4 R5 R6)
    for (int v = 0; v < NV; v++) begin
      do_reset();
      arm_en = 1; per_a = VEC[v][2]; per_b = VEC[v][3]; model_on = 1; viol = 0;
      pair_mon = (VEC[v][0] == 3);
      pulse_start(VEC[v][0], VEC[v][1]);
      check(drive == 0, "R8 drive latency", drive, 0);
      wait_idle();
      pair_mon = 0;
      check(count_a == CNT_W'(VEC[v][4]), "R6 R3 count A", count_a, VEC[v][4]);
      check(count_b == CNT_W'(VEC[v][5]), "R6 R3 count B", count_b, VEC[v][5]);
      check(done && !busy && drive == 0, "R6 done", done, 1);
      check(!viol, "R5 fail-equal margin", viol, 0);
    end

    // R7 stall on boom B, with a stray start during the session (R2)
    do_reset();
    arm_en = 1; per_a = 3; per_b = 0; model_on = 1;
    pulse_start(2, 5);
    hi = 0;
    @(negedge clk);
    mode = 2'b01; start = 1; @(negedge clk); start = 0;
    if (drive[1]) hi++;
    for (int k = 0; k < 200 && busy; k++) begin
      if (drive[1]) hi++;
      @(negedge clk);
    end
    check(hi == STALL, "R7 stall timeout length", hi, STALL);
    check(stall == 2'b10 && !done && !busy, "R7 stall flags", stall, 2);
    check(count_a == 0, "R2 stray start ignored", count_a, 0);
    pulse_start(0, 0);
    @(negedge clk);
    check(stall == 0 && done, "R7 stall cleared R3 empty mode", stall, 0);

    // R1 enable drop mid-session
    do_reset();
    arm_en = 1; per_a = 3; per_b = 3; model_on = 1;
    pulse_start(3, 20);
    repeat (10) @(negedge clk);
    check(drive == 2'b11, "R1 running before drop", drive, 3);
    arm_en = 0; #1;
    check(drive == 0, "R1 same-cycle gate", drive, 0);
    @(negedge clk);
    check(!busy, "R1 session ended", busy, 0);
    model_on = 0; sa = count_a; sb = count_b;
    man_click = 2'b11; @(negedge clk); man_click = 0; @(negedge clk);
    check(count_a == sa && count_b == sb, "R4 frozen counts", count_a, sa);
    arm_en = 1; repeat (3) @(negedge clk);
    check(!busy && drive == 0, "R1 no resume", drive, 0);

    finish_run();
  end
endmodule